// File: doc/BRIEF.md
# Byte-Buffered Modulo Timer Counter

This block is a 16-bit up-counter whose terminal count is set by a modulo value. Software writes that value over an 8-bit register bus, one byte at a time. Each byte first goes into a write buffer. The active modulo only takes the buffered pair as one coherent 16-bit value. The count therefore never runs against a half-written limit.

A two-bit clock-select field controls both counting and loading. When the field is zero the counter is stopped, and a completed byte pair loads immediately. When the field is non-zero the counter advances on each prescaler tick. A completed pair then waits until the count steps into the old terminal value. When the active modulo is zero the counter runs free over the whole 16-bit range. On wrap the counter returns to zero and raises a sticky overflow flag. A write to the counter address clears the count and discards any half-finished byte pair.

Top module: `tmr_modulo_timer`

## Requirements
- R1: After reset, the count, the active modulo, the overflow flag and the clock-select field are all zero.
- R2: A write to only one modulo byte (address 1 is the high byte, address 2 the low byte) leaves the active modulo unchanged.
- R3: With clock-select 00, the active modulo takes the buffered pair on the clock edge of the write that completes the pair. The bytes may be written in either order.
- R4: With clock-select non-zero, a completed pair loads only on the edge where a tick moves the count from (active modulo − 1) to the active modulo. Until then the old modulo stays in force.
- R5: With an active modulo of 0, a pending pair loads on the tick that moves the count from 0xFFFE to 0xFFFF.
- R6: The count changes only on a tick while clock-select (control address 0, bits 1:0) is non-zero. Ticks while it is 00 leave the count unchanged.
- R7: A tick at the terminal count wraps the count to 0 and sets the overflow flag. The terminal count is the active modulo, or 0xFFFF for modulo 0 or a count above the modulo. The flag stays set until a control write with bit 6 high. A wrap in the same cycle wins over the clear.
- R8: A write to address 3 clears the count to 0 and forgets which modulo bytes were written. A later single byte write then does not complete a pair.
- R9: The select view shows clock-select in bits 1:0 and the overflow flag in bit 7, with the other bits zero.
- R10: Writing the same modulo byte twice does not complete a pair. The later value replaces the earlier one in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler tick; advances the count when enabled |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 modulo high, 2 modulo low, 3 counter |
| wdata_i | input | 8 | Register write data |
| count_o | output | 16 | Current count |
| modulo_o | output | 16 | Active modulo value |
| ovf_o | output | 1 | Sticky overflow flag |
| sel_view_o | output | 8 | Select register view |

## Verification
Modulo pairs are written high-first and low-first, with repeated writes to one byte and with a counter write placed between the two bytes. This separates a real pair completion from a mere second write. Loads are tried with the counter stopped and with it running. In the running case the test probes the edges just before and at the old terminal step, which shows whether the load waits for the safe point. Ticks come both back to back and with idle gaps, and are also given while the counter is stopped. A long free-running pass through 0xFFFE and 0xFFFF covers the zero-modulo load point and the full-range wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W = 8;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MODH = 2'd1;
    localparam logic [1:0] ADDR_MODL = 2'd2;
    localparam logic [1:0] ADDR_CNT  = 2'd3;
    localparam int CLR_BIT = 6;
endpackage

// File: rtl/tmr_modbuf.sv
module tmr_modbuf #(
    parameter int BW = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        byte_we_i,
    input  logic [BW-1:0]     wdata_i,
    input  logic              running_i,
    input  logic              load_pt_i,
    input  logic              flush_i,
    output logic [2*BW-1:0]   mod_o
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        logic [1:0][BW-1:0] bytes;
        logic [1:0]         seen;
        logic [CW-1:0]      mod;
    } mb_t;

    mb_t q, d;
    logic [1:0] other_seen;
    logic       stop_load;
    logic       run_load;

    always_comb begin
        d = q;
        other_seen = {q.seen[0], q.seen[1]};
        stop_load = !running_i && (|(byte_we_i & other_seen));
        run_load  = running_i && (&q.seen) && load_pt_i;
        for (int i = 0; i < 2; i++) begin
            if (byte_we_i[i]) d.bytes[i] = wdata_i;
        end
        if (flush_i) begin
            d.seen = '0;
        end else if (stop_load) begin
            d.mod  = {d.bytes[1], d.bytes[0]};
            d.seen = '0;
        end else if (run_load) begin
            d.mod  = {q.bytes[1], q.bytes[0]};
            d.seen = byte_we_i;
        end else begin
            d.seen = q.seen | byte_we_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign mod_o = q.mod;

    // R2: without both bytes marked, the active value cannot move
    p_hold_mod_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(&(q.seen | byte_we_i)) |=> $stable(q.mod));

    // R4: while running, only the safe step may load
    p_run_point_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running_i && !load_pt_i) |=> $stable(q.mod));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int CW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          adv_i,
    input  logic          clr_i,
    input  logic [CW-1:0] mod_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          load_pt_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cs_t;

    cs_t q, d;
    logic [CW-1:0] term;
    logic          at_top;

    always_comb begin
        d = q;
        wrap_o = 1'b0;
        load_pt_o = 1'b0;
        term = (mod_i == '0) ? '1 : mod_i;
        at_top = (q.cnt == term) || (q.cnt == '1);
        if (clr_i) begin
            d.cnt = '0;
        end else if (adv_i) begin
            load_pt_o = (q.cnt == term - 1'b1);
            if (at_top) begin
                d.cnt  = '0;
                wrap_o = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign cnt_o = q.cnt;

    // R6: no tick or no enable means the count holds
    p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!adv_i && !clr_i) |=> $stable(q.cnt));

    // R7: advancing at the ceiling returns to zero
    p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !clr_i && q.cnt == '1) |=> (q.cnt == '0));
endmodule

// File: rtl/tmr_modulo_timer.sv
module tmr_modulo_timer
    import tmr_pkg::*;
#(
    parameter int BW = tmr_pkg::BYTE_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            tick_i,
    input  logic            we_i,
    input  logic [1:0]      addr_i,
    input  logic [BW-1:0]   wdata_i,
    output logic [2*BW-1:0] count_o,
    output logic [2*BW-1:0] modulo_o,
    output logic            ovf_o,
    output logic [7:0]      sel_view_o
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        logic [1:0] sel;
        logic       ovf;
    } ctl_t;

    ctl_t q, d;
    logic          running;
    logic          adv;
    logic          cnt_clr;
    logic          ctl_wr;
    logic [1:0]    byte_we;
    logic          wrap;
    logic          load_pt;
    logic [CW-1:0] mod_act;

    assign running = (q.sel != 2'b00);
    assign adv     = tick_i && running;
    assign cnt_clr = we_i && (addr_i == ADDR_CNT);
    assign ctl_wr  = we_i && (addr_i == ADDR_CTRL);
    assign byte_we = {we_i && (addr_i == ADDR_MODH), we_i && (addr_i == ADDR_MODL)};

    always_comb begin
        d = q;
        if (ctl_wr) begin
            d.sel = wdata_i[1:0];
            if (wdata_i[CLR_BIT]) d.ovf = 1'b0;
        end
        if (wrap) d.ovf = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    tmr_modbuf #(.BW(BW)) u_buf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .byte_we_i (byte_we),
        .wdata_i   (wdata_i),
        .running_i (running),
        .load_pt_i (load_pt),
        .flush_i   (cnt_clr),
        .mod_o     (mod_act)
    );

    tmr_count #(.CW(CW)) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .adv_i     (adv),
        .clr_i     (cnt_clr),
        .mod_i     (mod_act),
        .cnt_o     (count_o),
        .wrap_o    (wrap),
        .load_pt_o (load_pt)
    );

    assign modulo_o   = mod_act;
    assign ovf_o      = q.ovf;
    assign sel_view_o = {q.ovf, 5'b00000, q.sel};

    // R7: the flag only drops through an explicit clear write
    p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ovf && !(ctl_wr && wdata_i[CLR_BIT])) |=> q.ovf);

    // R7: a wrap always leaves the flag set
    p_ovf_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> q.ovf);
endmodule

// File: tb/tmr_modulo_timer_test.sv
module tmr_modulo_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'd0;
    logic [15:0] count;
    logic [15:0] modulo;
    logic        ovf;
    logic [7:0]  view;

    always #5 clk = ~clk;

    tmr_modulo_timer uut (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .count_o(count), .modulo_o(modulo), .ovf_o(ovf),
        .sel_view_o(view)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_mod, m_bh, m_bl, m_sel;
    bit m_fh, m_fl, m_ovf;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 0; m_bh = 0; m_bl = 0; m_sel = 0;
            m_fh = 0; m_fl = 0; m_ovf = 0;
        end else begin
            int  lim, n_cnt, n_mod, n_bh, n_bl;
            bit  adv, clr, lp, wr_h, wr_l, n_fh, n_fl, wrapped;
            lim  = (m_mod == 0) ? 65535 : m_mod;
            adv  = tick && (m_sel != 0);
            clr  = we && addr == 2'd3;
            wr_h = we && addr == 2'd1;
            wr_l = we && addr == 2'd2;
            lp   = adv && (m_cnt == lim - 1);
            wrapped = 0;
            n_cnt = m_cnt;
            if (clr) n_cnt = 0;
            else if (adv) begin
                if (m_cnt == lim || m_cnt == 65535) begin n_cnt = 0; wrapped = 1; end
                else n_cnt = m_cnt + 1;
            end
            n_bh = wr_h ? int'(wdata) : m_bh;
            n_bl = wr_l ? int'(wdata) : m_bl;
            n_mod = m_mod;
            n_fh = m_fh | wr_h;
            n_fl = m_fl | wr_l;
            if (clr) begin n_fh = 0; n_fl = 0; end
            else if (m_sel == 0 && ((wr_h && m_fl) || (wr_l && m_fh))) begin
                n_mod = n_bh * 256 + n_bl; n_fh = 0; n_fl = 0;
            end else if (m_sel != 0 && m_fh && m_fl && lp) begin
                n_mod = m_bh * 256 + m_bl; n_fh = wr_h; n_fl = wr_l;
            end
            if (we && addr == 2'd0) begin
                m_sel = int'(wdata[1:0]);
                if (wdata[6]) m_ovf = 0;
            end
            if (wrapped) m_ovf = 1;
            m_cnt = n_cnt; m_mod = n_mod; m_bh = n_bh; m_bl = n_bl;
            m_fh = n_fh; m_fl = n_fl;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 count vs model", int'(count), m_cnt);
            chk("R3 modulo vs model", int'(modulo), m_mod);
            chk("R7 overflow vs model", int'(ovf), int'(m_ovf));
            chk("R9 view vs model", int'(view), m_ovf * 128 + m_sel);
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] v);
        @(negedge clk); we = 1'b1; addr = a; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic tk(int n);
        repeat (n) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R6 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count reset", int'(count), 0);
        chk("R1 modulo reset", int'(modulo), 0);
        chk("R1 view reset", int'(view), 0);

        // stopped loads, high byte first
        wr(2'd1, 8'h00);
        chk("R2 single high byte", int'(modulo), 0);
        wr(2'd2, 8'h05);
        chk("R3 stopped load", int'(modulo), 5);
        // low first, with a repeated low write
        wr(2'd2, 8'h09);
        chk("R2 single low byte", int'(modulo), 5);
        wr(2'd2, 8'h07);
        chk("R10 same byte twice", int'(modulo), 5);
        wr(2'd1, 8'h00);
        chk("R3 low-first load", int'(modulo), 7);
        // ticks while stopped
        tk(4);
        chk("R6 stopped ignores ticks", int'(count), 0);

        // run with gaps between ticks
        wr(2'd0, 8'h01);
        repeat (3) tk(1);
        chk("R6 gapped ticks", int'(count), 3);
        tk(4);
        chk("R7 at terminal", int'(count), 7);
        chk("R7 no flag yet", int'(ovf), 0);
        tk(1);
        chk("R7 wrap to zero", int'(count), 0);
        chk("R7 flag set", int'(ovf), 1);
        chk("R9 view with flag", int'(view), 8'h81);
        tk(2);
        chk("R7 flag sticky", int'(ovf), 1);
        wr(2'd0, 8'h41);
        chk("R7 flag cleared", int'(ovf), 0);
        chk("R9 view after clear", int'(view), 8'h01);

        // running load waits for the safe step
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h0A);
        chk("R4 pair pending", int'(modulo), 7);
        tk(4);
        chk("R4 before step", int'(count), 6);
        chk("R4 still old", int'(modulo), 7);
        tk(1);
        chk("R4 loaded at step", int'(modulo), 10);
        tk(3);
        chk("R4 new limit used", int'(count), 10);
        chk("R4 no early wrap", int'(ovf), 0);
        tk(1);
        chk("R4 wrap at new limit", int'(ovf), 1);
        wr(2'd0, 8'h41);

        // counter write drops a half pair
        wr(2'd0, 8'h00);
        tk(2);
        wr(2'd1, 8'h12);
        wr(2'd3, 8'h00);
        chk("R8 count cleared", int'(count), 0);
        wr(2'd2, 8'h34);
        chk("R8 half pair forgotten", int'(modulo), 10);
        wr(2'd1, 8'h00);
        chk("R3 load after flush", int'(modulo), 16'h0034);

        // free-running pass
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        chk("R3 modulo zero", int'(modulo), 0);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h20);
        chk("R5 pending while running", int'(modulo), 0);
        tk(65533);
        chk("R5 count FFFD", int'(count), 16'hFFFD);
        tk(1);
        chk("R5 no load at FFFE", int'(modulo), 0);
        tk(1);
        chk("R5 count FFFF", int'(count), 16'hFFFF);
        chk("R5 loaded at FFFF", int'(modulo), 16'h0020);
        tk(1);
        chk("R7 full-range wrap", int'(count), 0);
        chk("R7 full-range flag", int'(ovf), 1);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule